// File: doc/BRIEF.md
# Prioritised Interrupt Source Controller

This block watches a set of level-sensitive interrupt lines. It holds one priority register for each line and, every clock, chooses the most favoured line that is asserted and not masked. The chosen line's number and priority go to a downstream presentation stage, together with a request flag. The presentation stage, its accept and end-of-interrupt handshake, and routing to several targets all live outside this block.

Software reaches the block over a small register bus. Address 0 holds a read-only configuration register that reports how many priority bits are implemented. Each source has a read/write priority register at address source+1. The stored priority field is `PRIO_BITS` wide, which may be narrower than a full byte (the default is 3). The all-ones code of that field masks the source, and a masked register reads back as 0xff whatever the implemented width. A numerically lower priority is more favoured.

Top module: `isc_top`

## Requirements
- R1: After reset every source priority register reads 0xff (masked), and `irq_req` is low with `irq_src` at 0 and `irq_prio` at 0xff.
- R2: Address 0 reads `PRIO_BITS` as an unsigned 8-bit value. Writes to address 0 are ignored.
- R3: A write to address s+1 stores bits [PRIO_BITS-1:0] of the write data as the priority of source s and drops the upper bits. Reads of a non-masked register return the stored field zero-extended to 8 bits.
- R4: When every stored bit of a source's field is one, that register reads back as 0xff. This holds after writes of 0xff and after writes of any value whose low `PRIO_BITS` bits are all ones.
- R5: A masked source never raises `irq_req`, even while its line is asserted.
- R6: Among the eligible sources, the one with the numerically lowest priority is selected.
- R7: When eligible sources share the lowest priority, the one with the lowest source number is selected.
- R8: When no source is both asserted and unmasked, `irq_req` is low, `irq_src` is 0 and `irq_prio` is 0xff.
- R9: `irq_req`, `irq_src` and `irq_prio` are registered. They reflect the line levels and priority registers one clock edge after those change, and they never change between edges.
- R10: A request is presented only for a line that is asserted. When a line is dropped, its request is withdrawn and the next eligible source is selected.
- R11: While `irq_req` is high, `irq_prio` equals the selected source's stored field zero-extended to 8 bits, which is always below the all-ones code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt lines, bit s is source s |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 is configuration, s+1 is source s |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational; out-of-range addresses read 0 |
| irq_req | output | 1 | Request to the presentation stage |
| irq_src | output | SRC_W | Number of the selected source |
| irq_prio | output | 8 | Priority of the selected source, 0xff when idle |

## Verification
Priority writes use in-range values, values with upper bits set, exact all-ones low bits and 0xff. These patterns separate correct narrowing from storing the full byte and from masking on the wrong code. Selection is tried with two sources at different priorities, with the favoured one then demoted, and with two sources at equal priority. These cases show whether the comparison runs in the right direction and whether ties go to the lower number. Masked lines held high, favoured registers whose lines are low, and dropped lines show that both the line and the mask gate eligibility. A line raised just before an edge and checked on both sides of that edge shows whether the outputs are registered or pass straight through.

// File: rtl/isc_pkg.sv
package isc_pkg;

  // all-ones code of an implemented field, placed in a byte
  function automatic logic [7:0] field_ones(input int unsigned bits);
    return 8'((9'd1 << bits) - 9'd1);
  endfunction

  // true when the implemented bits of a field are all ones (masked)
  function automatic logic field_is_masked(input logic [7:0] field, input int unsigned bits);
    return (field & field_ones(bits)) == field_ones(bits);
  endfunction

  // software view of a stored field
  function automatic logic [7:0] field_readback(input logic [7:0] field, input int unsigned bits);
    if (field_is_masked(field, bits)) return 8'hff;
    return field & field_ones(bits);
  endfunction

endpackage

// File: rtl/isc_prio_regs.sv
module isc_prio_regs #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [7:0]                        wdata,
  output logic [NUM_SRC-1:0][PRIO_BITS-1:0] fields,
  output logic [7:0]                        rd_data
);
  import isc_pkg::*;

  localparam logic [7:0] CFG_VALUE = 8'(PRIO_BITS);

  // one register per source, reset to masked
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(s + 1));
    always_ff @(posedge clk) begin
      if (rst)      fields[s] <= '1;
      else if (hit) fields[s] <= wdata[PRIO_BITS-1:0];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == '0) rd_data = CFG_VALUE;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == ADDR_W'(s + 1)) rd_data = field_readback(8'(fields[s]), PRIO_BITS);
    end
  end

endmodule

// File: rtl/isc_arbiter.sv
module isc_arbiter #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  parameter int SRC_W     = 4
) (
  input  logic [NUM_SRC-1:0]                lines,
  input  logic [NUM_SRC-1:0][PRIO_BITS-1:0] fields,
  output logic [NUM_SRC-1:0]                eligible,
  output logic                              sel_valid,
  output logic [SRC_W-1:0]                  sel_idx,
  output logic [PRIO_BITS-1:0]              sel_prio
);
  import isc_pkg::*;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign eligible[s] = lines[s] && !field_is_masked(8'(fields[s]), PRIO_BITS);
  end

  // strict less-than keeps the lower index on ties
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_prio  = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (eligible[s] && (!sel_valid || fields[s] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_idx   = SRC_W'(s);
        sel_prio  = fields[s];
      end
    end
  end

endmodule

// File: rtl/isc_out_stage.sv
module isc_out_stage #(
  parameter int PRIO_BITS = 3,
  parameter int SRC_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_valid,
  input  logic [SRC_W-1:0]     sel_idx,
  input  logic [PRIO_BITS-1:0] sel_prio,
  output logic                 irq_req,
  output logic [SRC_W-1:0]     irq_src,
  output logic [7:0]           irq_prio
);
  always_ff @(posedge clk) begin
    if (rst || !sel_valid) begin
      irq_req  <= 1'b0;
      irq_src  <= '0;
      irq_prio <= 8'hff;
    end else begin
      irq_req  <= 1'b1;
      irq_src  <= sel_idx;
      irq_prio <= 8'(sel_prio);
    end
  end
endmodule

// File: rtl/isc_top.sv
module isc_top #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  localparam int ADDR_W   = $clog2(NUM_SRC + 1),
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               irq_req,
  output logic [SRC_W-1:0]   irq_src,
  output logic [7:0]         irq_prio
);
  logic [NUM_SRC-1:0][PRIO_BITS-1:0] fields;
  logic [NUM_SRC-1:0]                eligible;
  logic                              sel_valid;
  logic [SRC_W-1:0]                  sel_idx;
  logic [PRIO_BITS-1:0]              sel_prio;

  isc_prio_regs #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .fields(fields), .rd_data(bus_rdata)
  );

  isc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .SRC_W(SRC_W)) u_arb (
    .lines(src_lvl), .fields(fields), .eligible(eligible),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio)
  );

  isc_out_stage #(.PRIO_BITS(PRIO_BITS), .SRC_W(SRC_W)) u_out (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio),
    .irq_req(irq_req), .irq_src(irq_src), .irq_prio(irq_prio)
  );

endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 5,
  parameter int SRC_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [7:0]         bus_rdata,
  input logic               irq_req,
  input logic [SRC_W-1:0]   irq_src,
  input logic [7:0]         irq_prio,
  input logic               sel_valid
);
  localparam logic [7:0] ONES = 8'((9'd1 << PRIO_BITS) - 9'd1);

  logic [NUM_SRC-1:0] lvl_d;
  always_ff @(posedge clk) lvl_d <= src_lvl;

  // R2
  cfg_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |-> (bus_rdata == 8'(PRIO_BITS)));

  // R4
  readback_code_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != '0) |-> (bus_rdata == 8'hff || bus_rdata < ONES || bus_rdata == 8'h00));

  // R8
  idle_output_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_prio == 8'hff && irq_src == '0));

  // R9
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == $past(sel_valid)));

  // R10
  req_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> lvl_d[irq_src]);

  // R11
  req_prio_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_prio < ONES));

endmodule

bind isc_top isc_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_req(irq_req), .irq_src(irq_src), .irq_prio(irq_prio), .sel_valid(sel_valid)
);

// File: tb/sim_isc_top.sv
module sim_isc_top;
  localparam int N  = 16;
  localparam int PB = 3;
  localparam int AW = $clog2(N + 1);
  localparam int SW = $clog2(N);
  localparam logic [7:0] LOWM = 8'((9'd1 << PB) - 9'd1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_lvl = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq_req;
  logic [SW-1:0] irq_src;
  logic [7:0]    irq_prio;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] ref_rb [N];

  always #4 clk = ~clk;

  isc_top #(.NUM_SRC(N), .PRIO_BITS(PB)) u0 (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_src(irq_src), .irq_prio(irq_prio)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // software view a write should produce, stated from R3/R4
  function automatic logic [7:0] model_rb(input logic [7:0] d);
    logic [7:0] low = d & LOWM;
    return (low == LOWM) ? 8'hff : low;
  endfunction

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic set_prio(input int s, input logic [7:0] d);
    bus_write(s + 1, d);
    ref_rb[s] = model_rb(d);
  endtask

  // compare outputs with the selection rule of R6/R7/R8
  task automatic check_out(input string tag);
    int best = 8'hff; int idx = 0; bit found = 0;
    @(negedge clk); @(negedge clk);
    for (int s = 0; s < N; s++)
      if (src_lvl[s] && ref_rb[s] != 8'hff && (!found || ref_rb[s] < best)) begin
        found = 1; best = ref_rb[s]; idx = s;
      end
    check({tag, " req"},  irq_req,  found);
    check({tag, " src"},  irq_src,  idx);
    check({tag, " prio"}, irq_prio, best);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 req after reset", irq_req, 0);
    check("R1 prio after reset", irq_prio, 8'hff);
    for (int s = 0; s < N; s++) begin
      bus_read(s + 1, d);
      check("R1 masked readback", d, 8'hff);
      ref_rb[s] = 8'hff;
    end
  endtask

  task automatic t_config();
    logic [7:0] d;
    bus_read(0, d);
    check("R2 config width", d, PB);
    bus_write(0, 8'h55);
    bus_read(0, d);
    check("R2 config write ignored", d, PB);
  endtask

  task automatic t_narrow();
    logic [7:0] d;
    set_prio(0, 8'h05); bus_read(1, d); check("R3 plain value", d, 8'h05);
    set_prio(0, 8'hFA); bus_read(1, d); check("R3 upper bits dropped", d, 8'h02);
    set_prio(0, 8'h07); bus_read(1, d); check("R4 low ones masked", d, 8'hff);
    set_prio(0, 8'h0F); bus_read(1, d); check("R4 ones with upper bits", d, 8'hff);
    set_prio(0, 8'h00); bus_read(1, d); check("R3 zero value", d, 8'h00);
    set_prio(0, 8'hFF); bus_read(1, d); check("R4 full ones", d, 8'hff);
  endtask

  task automatic t_mask();
    src_lvl = '1;
    check_out("R5 all masked lines high");
    check("R5 no request", irq_req, 0);
    set_prio(3, 8'h07);
    src_lvl = '0; src_lvl[3] = 1'b1;
    check_out("R5 masked by write");
  endtask

  task automatic t_prio();
    set_prio(2, 8'h05);
    set_prio(9, 8'h01);
    src_lvl = '0; src_lvl[2] = 1'b1; src_lvl[9] = 1'b1;
    check_out("R6 lower value wins");
    check("R11 prio zero-extended", irq_prio, 8'h01);
    set_prio(9, 8'h06);
    check_out("R6 demoted source loses");
    check("R6 winner", irq_src, 2);
  endtask

  task automatic t_tie();
    set_prio(2, 8'hFF); set_prio(9, 8'hFF);
    set_prio(4, 8'h03); set_prio(11, 8'h03);
    src_lvl = '0; src_lvl[4] = 1'b1; src_lvl[11] = 1'b1;
    check_out("R7 tie");
    check("R7 lower number wins", irq_src, 4);
    set_prio(0, 8'h00);
    check_out("R10 favoured but line low");
  endtask

  task automatic t_level();
    src_lvl[4] = 1'b0;
    check_out("R10 dropped line");
    check("R10 next source", irq_src, 11);
    src_lvl = '0;
    check_out("R8 idle");
    check("R8 idle prio", irq_prio, 8'hff);
  endtask

  task automatic t_latency();
    set_prio(5, 8'h02);
    @(negedge clk);
    src_lvl = '0; src_lvl[5] = 1'b1;
    #1 check("R9 no change before edge", irq_req, 0);
    @(negedge clk);
    check("R9 one edge later req", irq_req, 1);
    check("R9 one edge later src", irq_src, 5);
    src_lvl[5] = 1'b0;
    #1 check("R9 held until edge", irq_req, 1);
    @(negedge clk);
    check("R9 withdrawn after edge", irq_req, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_config();
    t_narrow();
    t_mask();
    t_prio();
    t_tie();
    t_level();
    t_latency();
    finish_run();
  end

endmodule